// File: doc/BRIEF.md
# Fence Protection and Privilege Checker

This block guards a simple accumulator machine against two kinds of misuse by a program running in user mode. The first is a memory access to any address below a boundary register, the fence, which marks off the handler region at the bottom of memory. The second is the decode of an opcode that only the supervisor may run. Each violation sets a sticky flag, and the interrupt unit reads those flags. A combinational grant output lets the memory operation go ahead only when no fence violation exists in that same cycle.

The fence register is loaded through a dedicated port. The load takes effect only in supervisor mode. A load attempted in user mode leaves the fence unchanged and counts as a privilege violation. In supervisor mode every address and every opcode is allowed. The fence resets to zero, so no memory is protected until the supervisor sets a boundary. Opcodes are privileged when they are numerically greater than a parameterised last unprivileged code, which defaults to 59.

Top module: `prot_guard_top`

## Requirements
- R1: After a synchronous active-low reset, both flags (`mp_flag`, `pi_flag`) read 0 and the fence holds 0, so a user access to address 0 is granted.
- R2: `acc_grant` is combinational: in the same cycle as the request it equals `acc_valid` AND NOT (a fence violation in that cycle).
- R3: A user-mode (`mode_sup`=0) access with `acc_addr` < fence drives `acc_grant` low in that cycle and sets `mp_flag` on the next clock edge.
- R4: A user-mode access with `acc_addr` >= fence, including `acc_addr` equal to the fence, is granted and does not set `mp_flag`.
- R5: In supervisor mode (`mode_sup`=1) every access is granted, and neither accesses nor opcodes set any flag.
- R6: With `op_valid`=1 in user mode, an `op_code` greater than `LAST_USER_OP` sets `pi_flag` on the next edge. An `op_code` equal to `LAST_USER_OP` does not.
- R7: A supervisor-mode `fence_wr` loads `fence_wdata`, and the new fence applies to accesses from the following cycle on.
- R8: A user-mode `fence_wr` leaves the fence unchanged and sets `pi_flag` on the next edge.
- R9: Each flag stays set until its own clear input (`mp_clr`, `pi_clr`) is pulsed. A clear for one flag leaves the other flag unchanged.
- R10: When a violation and a clear for the same flag arrive in the same cycle, the flag is set afterward.
- R11: When `acc_valid` is 0, `acc_grant` is 0 and no memory violation is recorded. When `op_valid` is 0, `op_code` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sup | input | 1 | 1 = supervisor, 0 = user |
| acc_valid | input | 1 | Memory access request this cycle |
| acc_addr | input | ADDR_W | Address held in the memory address register |
| op_valid | input | 1 | Opcode decode strobe |
| op_code | input | OP_W | Opcode field of the instruction register |
| fence_wr | input | 1 | Fence load request |
| fence_wdata | input | ADDR_W | New fence value |
| mp_clr | input | 1 | Clear for the memory-protection flag |
| pi_clr | input | 1 | Clear for the privileged-instruction flag |
| acc_grant | output | 1 | Memory operation may proceed this cycle |
| mp_flag | output | 1 | Sticky memory-protection violation flag |
| pi_flag | output | 1 | Sticky privileged-instruction violation flag |

## Verification
On every cycle, the assertions check the following. A user access below the current fence is refused and flagged. Supervisor accesses are always granted. An idle strobe never grants. Privileged user opcodes and user fence loads raise `pi_flag`. A user fence load leaves the fence stable, and flags hold until cleared. Some behaviours show only in the bench's scenarios, because they depend on a chain of events. These are the fence at zero after reset protecting nothing, and a new fence value changing the grant decision one cycle later. They also include the exact equality boundary at the fence and at `LAST_USER_OP`, and set winning over clear in the same cycle. A random mix of modes, addresses near the fence, opcodes around the threshold and clears then compares the grant and both flags against a cycle model.

// File: rtl/prot_pkg.sv
// Package: shared constants for the fence protection and privilege checker.
// Assumes: two sticky flags, indexed as below, in one flag bank.
package prot_pkg;
    localparam int unsigned FLAG_MP   = 0;
    localparam int unsigned FLAG_PI   = 1;
    localparam int unsigned NUM_FLAGS = 2;

    typedef enum logic {
        MODE_USER  = 1'b0,
        MODE_SUPER = 1'b1
    } cpu_mode_e;
endpackage

// File: rtl/fence_reg.sv
// Module: fence_reg
// Holds the protection boundary. A load is accepted only in supervisor mode.
// A user-mode load attempt is reported so that it can be flagged as a privilege
// violation. Assumes a synchronous active-low reset that clears the fence to 0.
module fence_reg #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  prot_pkg::cpu_mode_e mode,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] fence_q,
    output logic              bad_wr
);
    import prot_pkg::*;

    // Flags a load request made without supervisor rights.
    always_comb begin
        bad_wr = wr_req && (mode == MODE_USER);
    end

    // Register update: reset to 0, load only under supervisor mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fence_q <= '0;
        end else if (wr_req && (mode == MODE_SUPER)) begin
            fence_q <= wr_data;
        end
    end
endmodule

// File: rtl/addr_guard.sv
// Module: addr_guard
// Compares the access address with the fence and produces the same-cycle grant.
// Assumes the address is stable for the whole cycle in which acc_valid is high.
module addr_guard #(
    parameter int unsigned ADDR_W = 16
) (
    input  prot_pkg::cpu_mode_e mode,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] fence,
    output logic              acc_grant,
    output logic              mp_hit
);
    import prot_pkg::*;

    logic below_fence;

    // Unsigned boundary test: addresses strictly under the fence are protected.
    always_comb begin
        below_fence = (acc_addr < fence);
    end

    // Violation and grant decision for the current cycle.
    always_comb begin
        mp_hit    = acc_valid && (mode == MODE_USER) && below_fence;
        acc_grant = acc_valid && !mp_hit;
    end
endmodule

// File: rtl/priv_guard.sv
// Module: priv_guard
// Classifies a decoded opcode against the last unprivileged code and reports
// a privilege violation in user mode. A refused fence load counts as one too.
// Assumes privileged opcodes are exactly those numerically above LAST_USER_OP.
module priv_guard #(
    parameter int unsigned OP_W         = 7,
    parameter int unsigned LAST_USER_OP = 59
) (
    input  prot_pkg::cpu_mode_e mode,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic            bad_fence_wr,
    output logic            pi_hit
);
    import prot_pkg::*;

    localparam logic [OP_W-1:0] LastOp = OP_W'(LAST_USER_OP);

    logic is_priv;

    // Threshold comparison marking the privileged part of the opcode space.
    always_comb begin
        is_priv = (op_code > LastOp);
    end

    // Combines the opcode class, decode strobe and mode into one violation.
    always_comb begin
        pi_hit = (op_valid && is_priv && (mode == MODE_USER)) || bad_fence_wr;
    end
endmodule

// File: rtl/sticky_flags.sv
// Module: sticky_flags
// Bank of N set-dominant sticky flags, each with its own clear.
// Assumes set and clear are single-cycle pulses sampled on the clock edge.
module sticky_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_q
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // One flag: a set wins over a clear in the same cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else if (set_i[g]) begin
                flag_q[g] <= 1'b1;
            end else if (clr_i[g]) begin
                flag_q[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/prot_guard_top.sv
// Module: prot_guard_top
// Fence-based memory protection and opcode-threshold privilege checking for a
// one-accumulator machine. It produces a same-cycle access grant and two sticky
// violation flags for the interrupt unit. Assumes mode_sup is valid on every
// cycle and that flag clears come only from the interrupt unit.
module prot_guard_top #(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned OP_W         = 7,
    parameter int unsigned LAST_USER_OP = 59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sup,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              fence_wr,
    input  logic [ADDR_W-1:0] fence_wdata,
    input  logic              mp_clr,
    input  logic              pi_clr,
    output logic              acc_grant,
    output logic              mp_flag,
    output logic              pi_flag
);
    import prot_pkg::*;

    cpu_mode_e             mode;
    logic [ADDR_W-1:0]     fence_q;
    logic                  bad_wr;
    logic                  mp_hit;
    logic                  pi_hit;
    logic [NUM_FLAGS-1:0]  set_vec;
    logic [NUM_FLAGS-1:0]  clr_vec;
    logic [NUM_FLAGS-1:0]  flag_vec;

    // Mode bit decoded into the shared enumeration.
    always_comb begin
        mode = mode_sup ? MODE_SUPER : MODE_USER;
    end

    fence_reg #(.ADDR_W(ADDR_W)) u_fence (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .wr_req  (fence_wr),
        .wr_data (fence_wdata),
        .fence_q (fence_q),
        .bad_wr  (bad_wr)
    );

    addr_guard #(.ADDR_W(ADDR_W)) u_addr (
        .mode      (mode),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .fence     (fence_q),
        .acc_grant (acc_grant),
        .mp_hit    (mp_hit)
    );

    priv_guard #(.OP_W(OP_W), .LAST_USER_OP(LAST_USER_OP)) u_priv (
        .mode         (mode),
        .op_valid     (op_valid),
        .op_code      (op_code),
        .bad_fence_wr (bad_wr),
        .pi_hit       (pi_hit)
    );

    // Routes violations and clears into the flag bank slots.
    always_comb begin
        set_vec          = '0;
        clr_vec          = '0;
        set_vec[FLAG_MP] = mp_hit;
        set_vec[FLAG_PI] = pi_hit;
        clr_vec[FLAG_MP] = mp_clr;
        clr_vec[FLAG_PI] = pi_clr;
    end

    sticky_flags #(.N(NUM_FLAGS)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .flag_q (flag_vec)
    );

    // Drives the flag outputs from the bank.
    always_comb begin
        mp_flag = flag_vec[FLAG_MP];
        pi_flag = flag_vec[FLAG_PI];
    end
endmodule

// File: rtl/prot_guard_chk.sv
// Module: prot_guard_chk
// Property checker for prot_guard_top. It observes the ports and the fence
// register and is attached through the bind statement at the end of this file.
module prot_guard_chk #(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned OP_W         = 7,
    parameter int unsigned LAST_USER_OP = 59
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_sup,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_code,
    input logic              fence_wr,
    input logic [ADDR_W-1:0] fence_wdata,
    input logic              mp_clr,
    input logic              pi_clr,
    input logic              acc_grant,
    input logic              mp_flag,
    input logic              pi_flag,
    input logic [ADDR_W-1:0] fence_q
);
    localparam logic [OP_W-1:0] LastOp = OP_W'(LAST_USER_OP);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!mp_flag && !pi_flag && fence_q == '0));

    p_below_fence_denied_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !mode_sup && acc_addr < fence_q) |-> !acc_grant);

    p_below_fence_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !mode_sup && acc_addr < fence_q) |=> mp_flag);

    p_user_above_fence_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !mode_sup && acc_addr >= fence_q) |-> acc_grant);

    p_super_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mode_sup) |-> acc_grant);

    p_priv_op_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !mode_sup && op_code > LastOp) |=> pi_flag);

    p_fence_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_wr && mode_sup) |=> (fence_q == $past(fence_wdata)));

    p_user_fence_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_wr && !mode_sup) |=> ($stable(fence_q) && pi_flag));

    p_mp_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_flag && !mp_clr) |=> mp_flag);

    p_pi_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pi_flag && !pi_clr) |=> pi_flag);

    p_idle_no_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_grant);
endmodule

bind prot_guard_top prot_guard_chk #(
    .ADDR_W       (ADDR_W),
    .OP_W         (OP_W),
    .LAST_USER_OP (LAST_USER_OP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sup    (mode_sup),
    .acc_valid   (acc_valid),
    .acc_addr    (acc_addr),
    .op_valid    (op_valid),
    .op_code     (op_code),
    .fence_wr    (fence_wr),
    .fence_wdata (fence_wdata),
    .mp_clr      (mp_clr),
    .pi_clr      (pi_clr),
    .acc_grant   (acc_grant),
    .mp_flag     (mp_flag),
    .pi_flag     (pi_flag),
    .fence_q     (fence_q)
);

// File: tb/tb_prot_guard_top.sv
// Bench for prot_guard_top: directed corner cases followed by seeded random
// traffic, checked against a cycle model built from the requirements.
module tb_prot_guard_top;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned OP_W   = 7;
    localparam int unsigned LAST   = 59;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mode_sup = 1'b0;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic              op_valid = 1'b0;
    logic [OP_W-1:0]   op_code = '0;
    logic              fence_wr = 1'b0;
    logic [ADDR_W-1:0] fence_wdata = '0;
    logic              mp_clr = 1'b0;
    logic              pi_clr = 1'b0;
    logic              acc_grant;
    logic              mp_flag;
    logic              pi_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [ADDR_W-1:0] m_fence = '0;
    logic              m_mp = 1'b0;
    logic              m_pi = 1'b0;

    prot_guard_top #(.ADDR_W(ADDR_W), .OP_W(OP_W), .LAST_USER_OP(LAST)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sup(mode_sup), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .op_valid(op_valid), .op_code(op_code),
        .fence_wr(fence_wr), .fence_wdata(fence_wdata), .mp_clr(mp_clr),
        .pi_clr(pi_clr), .acc_grant(acc_grant), .mp_flag(mp_flag), .pi_flag(pi_flag)
    );

    always #10 clk = ~clk;

    function automatic logic f_mp_hit(logic sup, logic av, logic [ADDR_W-1:0] a,
                                      logic [ADDR_W-1:0] f);
        return av && !sup && (a < f);
    endfunction

    function automatic logic f_pi_hit(logic sup, logic ov, logic [OP_W-1:0] op, logic fw);
        return !sup && ((ov && (int'(op) > int'(LAST))) || fw);
    endfunction

    task automatic check(string tag, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check grant mid-phase, check flags after the edge.
    task automatic cycle(string tag, logic sup, logic av, logic [ADDR_W-1:0] a,
                         logic ov, logic [OP_W-1:0] op, logic fw,
                         logic [ADDR_W-1:0] fd, logic mc, logic pc);
        logic mph, pih;
        mode_sup = sup; acc_valid = av; acc_addr = a; op_valid = ov; op_code = op;
        fence_wr = fw; fence_wdata = fd; mp_clr = mc; pi_clr = pc;
        #2;
        mph = f_mp_hit(sup, av, a, m_fence);
        pih = f_pi_hit(sup, ov, op, fw);
        check(tag, acc_grant, av && !mph, "grant");
        @(posedge clk);
        #1;
        m_mp = mph ? 1'b1 : (mc ? 1'b0 : m_mp);
        m_pi = pih ? 1'b1 : (pc ? 1'b0 : m_pi);
        if (fw && sup) m_fence = fd;
        check(tag, mp_flag, m_mp, "mp_flag");
        check(tag, pi_flag, m_pi, "pi_flag");
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", mp_flag, 1'b0, "mp after reset");
        check("R1", pi_flag, 1'b0, "pi after reset");
        // R1: fence at 0 protects nothing.
        cycle("R1", 0, 1, 16'd0, 0, 0, 0, 0, 0, 0);
        // R7: supervisor loads fence 4000.
        cycle("R7", 1, 0, 0, 0, 0, 1, 16'd4000, 0, 0);
        // R3/R2: access just below the fence.
        cycle("R3", 0, 1, 16'd3999, 0, 0, 0, 0, 0, 0);
        // R9: mp holds across idle and pi clear.
        cycle("R9", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        cycle("R9", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cycle("R9", 0, 0, 0, 0, 0, 0, 0, 1, 0);
        // R4: boundary and top address.
        cycle("R4", 0, 1, 16'd4000, 0, 0, 0, 0, 0, 0);
        cycle("R4", 0, 1, 16'hFFFF, 0, 0, 0, 0, 0, 0);
        // R5: supervisor below fence and privileged opcode.
        cycle("R5", 1, 1, 16'd10, 1, 7'd100, 0, 0, 0, 0);
        // R6: threshold equality and one above.
        cycle("R6", 0, 0, 0, 1, 7'd59, 0, 0, 0, 0);
        cycle("R6", 0, 0, 0, 1, 7'd60, 0, 0, 0, 0);
        // R10: violation plus clear in the same cycle.
        cycle("R10", 0, 1, 16'd5, 1, 7'd60, 0, 0, 1, 1);
        cycle("R9", 0, 0, 0, 0, 0, 0, 0, 1, 1);
        // R8: user fence load ignored, PI raised, fence still 4000.
        cycle("R8", 0, 0, 0, 0, 0, 1, 16'd0, 0, 0);
        cycle("R8", 0, 1, 16'd3999, 0, 0, 0, 0, 0, 1);
        cycle("R8", 1, 0, 0, 0, 0, 0, 0, 1, 0);
        // R11: strobes low.
        cycle("R11", 0, 0, 16'd5, 0, 7'd100, 0, 0, 0, 0);
        // R7: new fence takes effect next cycle.
        cycle("R7", 1, 0, 0, 0, 0, 1, 16'd200, 0, 0);
        cycle("R7", 0, 1, 16'd300, 0, 0, 0, 0, 0, 0);
        cycle("R7", 0, 1, 16'd199, 0, 0, 0, 0, 1, 0);
        // Random traffic, addresses biased around the fence.
        for (int i = 0; i < 2000; i++) begin
            logic sup, av, ov, fw, mc, pc;
            logic [ADDR_W-1:0] a, fd;
            logic [OP_W-1:0] op;
            sup = ($urandom_range(3) == 0);
            av  = ($urandom_range(3) != 0);
            a   = ($urandom_range(1) == 0) ? ADDR_W'($urandom)
                  : ADDR_W'(int'(m_fence) + $urandom_range(4) - 2);
            ov  = $urandom_range(1);
            op  = OP_W'(LAST - 2 + $urandom_range(4));
            fw  = ($urandom_range(15) == 0);
            fd  = ADDR_W'($urandom_range(8000));
            mc  = ($urandom_range(7) == 0);
            pc  = ($urandom_range(7) == 0);
            cycle("R2", sup, av, a, ov, op, fw, fd, mc, pc);
        end
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule